// File: doc/BRIEF.md
# Conversion Mode Sequencer

This block sets the conversion timing of a sampling converter. A mode byte picks one of three behaviours: free-running conversion, a single power-up-and-convert pass, or staying powered off. Time is measured in pulses of a system tick, so the power-up wait and the output period are tick counts set by parameters. A signed raw sample, standing in for the digital filter output, is captured when a conversion completes. It is converted to unipolar or offset-binary code and held in a data register. A ready flag and a one-cycle done strobe tell the host that a new result is there.

A valid write to the mode byte restarts the sequence at once. It clears the ready flag and resets the tick counter. A write whose fixed bits hold the wrong values is dropped. In single mode the converter powers itself down after its one result. That result and its ready flag stay in place until the host reads the data.

Top module: `conv_mode_seq`

## Requirements
- R1: After reset the mode byte reads 0x02 (continuous, bipolar), `pwr_on_o` is 1, `rdy_o` and `done_o` are 0 and `data_o` is 0.
- R2: A mode write is accepted only when bits 5..3 are 0, bit 1 is 1 and bit 0 is 0. Any other write leaves the mode byte unchanged and does not restart the sequence.
- R3: In continuous mode (bits 7..6 = 00), `done_o` pulses after tick number 2*PERIOD_TICKS counted from the start. It then pulses after every further PERIOD_TICKS ticks. `pwr_on_o` stays 1.
- R4: In single mode (bits 7..6 = 10), the block stays powered for PWRUP_TICKS ticks plus 2*PERIOD_TICKS ticks. It pulses `done_o` once after the last of these ticks, and `pwr_on_o` drops to 0 in that same cycle. No further result follows until the next valid write.
- R5: Mode 11 (power-down) and mode 01 (reserved) both keep `pwr_on_o` at 0 and never pulse `done_o`.
- R6: `rdy_o` rises only together with `done_o`. It stays 1 until `data_rd_i` or a valid mode write. `data_o` changes only in a `done_o` cycle.
- R7: With bit 2 = 1 (unipolar), a negative sample gives code 0. A sample s >= 0 gives s shifted left by one, with bit DATA_W-2 of s copied into the LSB. So zero gives all zeros and the largest positive sample gives all ones.
- R8: With bit 2 = 0 (bipolar), the code is the sample with its MSB inverted (offset binary). The most negative sample gives all zeros, zero gives only the MSB set, and the largest positive sample gives all ones.
- R9: A valid mode write clears `rdy_o` and restarts tick counting from zero for the mode just written.
- R10: When `data_rd_i` falls in the same cycle as a completing conversion, the new result wins and `rdy_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | System time-base pulse, one cycle wide |
| mode_wr_i | input | 1 | Mode byte write strobe |
| mode_wdata_i | input | 8 | Mode byte write data |
| data_rd_i | input | 1 | Host has completed a data register read |
| sample_i | input | DATA_W | Raw signed filter sample |
| mode_reg_o | output | 8 | Current mode byte |
| pwr_on_o | output | 1 | Converter power enable |
| done_o | output | 1 | Conversion-complete strobe |
| rdy_o | output | 1 | Unread result present |
| data_o | output | DATA_W | Formatted result register |

## Verification
The hardest condition to reach is a host read landing in the very cycle a conversion completes. Only one tick out of every period can produce it. The stimulus tracks the expected completion tick and drives the read strobe on exactly that tick.

The coding extremes are just as narrow. These are the most negative sample, zero and the largest positive sample in both codings. They are placed on the completing tick as directed values, between stretches of random samples and random idle gaps.

// File: rtl/conv_mode_seq_pkg.sv
package conv_mode_seq_pkg;

  typedef enum logic [1:0] {
    MD_CONT   = 2'b00,
    MD_RSVD   = 2'b01,
    MD_SINGLE = 2'b10,
    MD_OFF    = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    ST_OFF,
    ST_RUN,
    ST_WARM,
    ST_SHOT
  } seq_state_e;

  localparam logic [7:0] MODE_RST = 8'h02;

  // fixed bits: [5:3] = 0, [1] = 1, [0] = 0
  function automatic logic fixed_ok(input logic [7:0] v);
    return (v[5:3] == 3'b000) && (v[1:0] == 2'b10);
  endfunction

endpackage

// File: rtl/conv_mode_seq_mode_reg.sv
module conv_mode_seq_mode_reg
  import conv_mode_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] q_o,
  output logic       apply_o
);

  logic [7:0] q;

  assign apply_o = wr_i && fixed_ok(wdata_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q <= MODE_RST;
    else if (apply_o) q <= wdata_i;
  end

  assign q_o = q;

endmodule

// File: rtl/conv_mode_seq_timer.sv
module conv_mode_seq_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             hit_o
);

  logic [CNT_W-1:0] cnt;

  assign hit_o = en_i && tick_i && (cnt == limit_i - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt <= '0;
    else if (clear_i)          cnt <= '0;
    else if (en_i && tick_i)   cnt <= hit_o ? '0 : cnt + CNT_W'(1);
  end

endmodule

// File: rtl/conv_mode_seq_fmt.sv
module conv_mode_seq_fmt #(
  parameter int DATA_W = 24
) (
  input  logic [DATA_W-1:0] raw_i,
  input  logic              unipolar_i,
  output logic [DATA_W-1:0] code_o
);

  always_comb begin
    if (unipolar_i) begin
      if (raw_i[DATA_W-1]) code_o = '0;
      else                 code_o = {raw_i[DATA_W-2:0], raw_i[DATA_W-2]};
    end else begin
      code_o = {~raw_i[DATA_W-1], raw_i[DATA_W-2:0]};
    end
  end

endmodule

// File: rtl/conv_mode_seq.sv
module conv_mode_seq
  import conv_mode_seq_pkg::*;
#(
  parameter int DATA_W       = 24,
  parameter int PWRUP_TICKS  = 1000,
  parameter int PERIOD_TICKS = 60241
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              mode_wr_i,
  input  logic [7:0]        mode_wdata_i,
  input  logic              data_rd_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic [7:0]        mode_reg_o,
  output logic              pwr_on_o,
  output logic              done_o,
  output logic              rdy_o,
  output logic [DATA_W-1:0] data_o
);

  localparam int MAX_LIM = (PWRUP_TICKS > 2*PERIOD_TICKS) ? PWRUP_TICKS : 2*PERIOD_TICKS;
  localparam int CNT_W   = $clog2(MAX_LIM + 1);
  localparam logic [CNT_W-1:0] LIM_WARM  = CNT_W'(PWRUP_TICKS);
  localparam logic [CNT_W-1:0] LIM_FIRST = CNT_W'(2*PERIOD_TICKS);
  localparam logic [CNT_W-1:0] LIM_NEXT  = CNT_W'(PERIOD_TICKS);

  logic [7:0]        mode_q;
  logic              apply;
  logic              hit;
  logic [CNT_W-1:0]  limit;
  logic [DATA_W-1:0] code;
  seq_state_e        state_q;
  logic              first_q, done_q, rdy_q;
  logic [DATA_W-1:0] data_q;
  logic              finish;
  mode_e             new_md;

  conv_mode_seq_mode_reg u_mode (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (mode_wr_i),
    .wdata_i (mode_wdata_i),
    .q_o     (mode_q),
    .apply_o (apply)
  );

  always_comb begin
    unique case (state_q)
      ST_WARM: limit = LIM_WARM;
      ST_RUN:  limit = first_q ? LIM_FIRST : LIM_NEXT;
      default: limit = LIM_FIRST;
    endcase
  end

  conv_mode_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (apply),
    .en_i    (state_q != ST_OFF),
    .tick_i  (tick_i),
    .limit_i (limit),
    .hit_o   (hit)
  );

  conv_mode_seq_fmt #(.DATA_W(DATA_W)) u_fmt (
    .raw_i      (sample_i),
    .unipolar_i (mode_q[2]),
    .code_o     (code)
  );

  assign finish = hit && ((state_q == ST_RUN) || (state_q == ST_SHOT));
  assign new_md = mode_e'(mode_wdata_i[7:6]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      first_q <= 1'b1;
      done_q  <= 1'b0;
      rdy_q   <= 1'b0;
      data_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (apply) begin
        rdy_q   <= 1'b0;
        first_q <= 1'b1;
        unique case (new_md)
          MD_CONT:   state_q <= ST_RUN;
          MD_SINGLE: state_q <= ST_WARM;
          default:   state_q <= ST_OFF;  // reserved treated as off
        endcase
      end else begin
        if (finish) begin
          done_q  <= 1'b1;
          rdy_q   <= 1'b1;
          data_q  <= code;
          first_q <= 1'b0;
        end else if (data_rd_i) begin
          rdy_q <= 1'b0;
        end
        unique case (state_q)
          ST_WARM: if (hit) state_q <= ST_SHOT;
          ST_SHOT: if (hit) state_q <= ST_OFF;
          default: ;
        endcase
      end
    end
  end

  assign mode_reg_o = mode_q;
  assign pwr_on_o   = (state_q != ST_OFF);
  assign done_o     = done_q;
  assign rdy_o      = rdy_q;
  assign data_o     = data_q;

endmodule

// File: rtl/conv_mode_seq_chk.sv
module conv_mode_seq_chk #(
  parameter int DATA_W = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [7:0]        mode_reg_o,
  input logic              pwr_on_o,
  input logic              done_o,
  input logic              rdy_o,
  input logic [DATA_W-1:0] data_o
);

  // R2
  fixed_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_reg_o[5:3] == 3'b000) && (mode_reg_o[1:0] == 2'b10));

  // R4
  single_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && mode_reg_o[7:6] == 2'b10) |-> !pwr_on_o);

  // R5
  off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_reg_o[6] == 1'b1) |-> (!pwr_on_o && !done_o));

  // R3
  cont_power_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_reg_o[7:6] == 2'b00) |-> pwr_on_o);

  // R6
  rdy_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdy_o) |-> done_o);

  // R6
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(data_o));

  // R10
  done_rdy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> rdy_o);

endmodule

bind conv_mode_seq conv_mode_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mode_reg_o (mode_reg_o),
  .pwr_on_o   (pwr_on_o),
  .done_o     (done_o),
  .rdy_o      (rdy_o),
  .data_o     (data_o)
);

// File: tb/conv_mode_seq_test.sv
module conv_mode_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int DW  = 16;
  localparam int WUP = 3;
  localparam int PER = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic          mode_wr = 1'b0;
  logic [7:0]    mode_wdata = '0;
  logic          data_rd = 1'b0;
  logic [DW-1:0] sample = '0;
  logic [7:0]    mode_reg;
  logic          pwr_on, done, rdy;
  logic [DW-1:0] data;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  // bench model state
  int            k = 0;
  logic [1:0]    md_m = 2'b00;
  logic          unip_m = 1'b0;
  logic          rdy_m = 1'b0;
  logic [DW-1:0] data_m = '0;
  logic [7:0]    reg_m = 8'h02;

  always #(CLK_PERIOD/2) clk = ~clk;

  conv_mode_seq #(.DATA_W(DW), .PWRUP_TICKS(WUP), .PERIOD_TICKS(PER)) uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .mode_wr_i(mode_wr),
    .mode_wdata_i(mode_wdata), .data_rd_i(data_rd), .sample_i(sample),
    .mode_reg_o(mode_reg), .pwr_on_o(pwr_on), .done_o(done), .rdy_o(rdy),
    .data_o(data)
  );

  function automatic logic [DW-1:0] fmt(input logic [DW-1:0] s, input logic u);
    if (u) return s[DW-1] ? '0 : {s[DW-2:0], s[DW-2]};
    return {~s[DW-1], s[DW-2:0]};
  endfunction

  function automatic bit exp_done(input logic [1:0] md, input int n);
    if (md == 2'b00) return (n >= 2*PER) && ((n - 2*PER) % PER == 0);
    if (md == 2'b10) return n == WUP + 2*PER;
    return 1'b0;
  endfunction

  function automatic bit exp_pwr(input logic [1:0] md, input int n);
    if (md == 2'b00) return 1'b1;
    if (md == 2'b10) return n < WUP + 2*PER;
    return 1'b0;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=0x%0h exp=0x%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic wr_mode(input logic [7:0] v);
    bit ok;
    ok = (v[5:3] == 3'b000) && (v[1:0] == 2'b10);
    @(negedge clk); mode_wr = 1'b1; mode_wdata = v;
    @(negedge clk); mode_wr = 1'b0;
    if (ok) begin
      reg_m = v; md_m = v[7:6]; unip_m = v[2]; k = 0; rdy_m = 1'b0;
      chk(rdy == 1'b0, "R9 rdy cleared by write", 32'(rdy), 0);
    end
    chk(mode_reg == reg_m, ok ? "R9 mode accepted" : "R2 bad write ignored", 32'(mode_reg), 32'(reg_m));
  endtask

  task automatic tk(input bit rd, input logic [DW-1:0] s);
    bit ed;
    string rq;
    k++;
    ed = exp_done(md_m, k);
    @(negedge clk); tick = 1'b1; sample = s; data_rd = rd;
    @(negedge clk); tick = 1'b0; data_rd = 1'b0;
    if (ed) begin
      data_m = fmt(s, unip_m);
      rdy_m  = 1'b1;
    end else if (rd) begin
      rdy_m = 1'b0;
    end
    rq = (md_m == 2'b00) ? "R3 done timing" : (md_m == 2'b10) ? "R4 done timing" : "R5 no done";
    chk(done == ed, rq, 32'(done), 32'(ed));
    chk(pwr_on == exp_pwr(md_m, k), (md_m == 2'b10) ? "R4 power" : "R5 power", 32'(pwr_on), 32'(exp_pwr(md_m, k)));
    chk(rdy == rdy_m, (rd && ed) ? "R10 read vs done" : "R6 ready", 32'(rdy), 32'(rdy_m));
    chk(data == data_m, unip_m ? "R7 unipolar code" : "R8 bipolar code", 32'(data), 32'(data_m));
    repeat ($urandom_range(0, 2)) @(negedge clk);
  endtask

  task automatic rd_only();
    @(negedge clk); data_rd = 1'b1;
    @(negedge clk); data_rd = 1'b0;
    rdy_m = 1'b0;
    chk(rdy == 1'b0, "R6 read clears ready", 32'(rdy), 0);
    chk(data == data_m, "R6 data held after read", 32'(data), 32'(data_m));
  endtask

  // run to the next completing tick with a chosen sample
  task automatic to_done(input logic [DW-1:0] s, input bit rd);
    while (!exp_done(md_m, k + 1)) tk(1'b0, DW'($urandom));
    tk(rd, s);
  endtask

  localparam logic [DW-1:0] S_MIN  = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] S_MAX  = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] S_ZERO = '0;

  initial begin
    void'($urandom(32'h1c3d));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(mode_reg == 8'h02, "R1 reset mode", 32'(mode_reg), 32'h02);
    chk(pwr_on == 1'b1, "R1 reset power", 32'(pwr_on), 1);
    chk(rdy == 1'b0 && done == 1'b0, "R1 reset flags", 32'({rdy, done}), 0);
    chk(data == '0, "R1 reset data", 32'(data), 0);

    // R3 continuous, random bipolar samples
    for (int i = 0; i < 18; i++) tk(1'b0, DW'($urandom));
    rd_only();

    // R2 invalid writes keep mode and timing
    wr_mode(8'h0A);
    wr_mode(8'hC3);
    wr_mode(8'h80);
    for (int i = 0; i < 6; i++) tk(1'b0, DW'($urandom));

    // R8 bipolar corners
    to_done(S_MIN, 1'b0);
    to_done(S_ZERO, 1'b0);
    to_done(S_MAX, 1'b0);

    // R9 restart mid-period, then R7 unipolar corners
    tk(1'b0, DW'($urandom));
    wr_mode(8'h06);
    to_done(S_ZERO, 1'b0);
    to_done(S_MAX, 1'b0);
    to_done(S_MIN, 1'b0);
    to_done(DW'(16'h4000), 1'b0);
    for (int i = 0; i < 10; i++) tk(1'b0, DW'($urandom));

    // R10 read colliding with completion
    to_done(DW'($urandom), 1'b1);
    tk(1'b1, DW'($urandom));

    // R4 single shot, bipolar
    wr_mode(8'h82);
    for (int i = 0; i < WUP + 2*PER + 6; i++) tk(1'b0, DW'($urandom));
    rd_only();
    tk(1'b0, DW'($urandom));

    // R4 single shot again, unipolar, read collision at completion
    wr_mode(8'h86);
    to_done(S_MAX, 1'b1);
    tk(1'b0, DW'($urandom));

    // R5 power-down and reserved
    wr_mode(8'hC2);
    for (int i = 0; i < 12; i++) tk(1'b0, DW'($urandom));
    wr_mode(8'h42);
    for (int i = 0; i < 12; i++) tk(1'b0, DW'($urandom));

    // back to continuous
    wr_mode(8'h02);
    for (int i = 0; i < 14; i++) tk(1'b0, DW'($urandom));

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule